// File: doc/BRIEF.md
# Multichannel Compare-Toggle Waveform Timer

This block is a 16-bit up-counting base timer shared by eight output-compare channels. Each channel holds a compare value. When the running counter equals that value, the channel inverts its waveform output and raises a match flag. The flag stays raised until software clears it.

The counter's period comes from one of three sources. It can run the full 16-bit range and wrap. It can restart after it equals channel 0's compare value. In that case channel 0 sets the period and its output no longer toggles. It can also restart after it equals a separate period register.

Each channel has an idle level, a polarity inversion and an output disable. Software programs the levels while the timer is stopped. It then starts the timer and sees the first edges at the programmed compare points.

Top module: `cmp_toggle_timer`

## Requirements
- R1: While `run_i` is 1 the counter advances by one per clock. While `run_i` is 0 the counter holds its value, and no channel toggles or flags.
- R2: With `rsel_i` = 2'b00 (and also 2'b11) the counter runs freely and wraps from FFFFh to 0000h on the next clock.
- R3: With `rsel_i` = 2'b01 the counter reaches channel 0's compare value and becomes 0000h on the following clock. Channel 0's toggle state does not change in this setting. Channels 1 to 7 keep working.
- R4: With `rsel_i` = 2'b10 the counter returns to 0000h on the clock after it equals `period_i`. Each cycle therefore spans `period_i`+1 clocks.
- R5: On a running clock where the counter equals a channel's compare slice (`cmp_i[16*j +: 16]`), that channel's toggle state inverts. The change is visible on `wave_o[j]` after that edge. A changed compare input is used from the next clock on, with no shadow register.
- R6: A match sets `flag_o[j]` on the following clock. A flag stays at 1 until a `flag_clr_i[j]` pulse clears it. A match in the same clock as a clear wins over the clear.
- R7: While stopped, each toggle state loads `idle_i[j]` (1 = high). Starting the timer leaves the outputs unchanged until the first match.
- R8: With `inv_i[j]` = 1 and the output enabled, `wave_o[j]` is the inverse of the toggle state.
- R9: With `out_dis_i[j]` = 1, `wave_o[j]` equals `idle_i[j]` regardless of toggle state and inversion. A value of 0 drives the waveform.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| run_i | input | 1 | Counter run enable |
| rsel_i | input | 2 | Period source: 00/11 free, 01 channel 0 compare, 10 period register |
| period_i | input | 16 | Period register value n |
| cmp_i | input | 128 | Compare values, channel j in bits 16j+15:16j |
| idle_i | input | 8 | Idle level per channel |
| inv_i | input | 8 | Output inversion per channel |
| out_dis_i | input | 8 | Output disable per channel (1 = show idle level) |
| flag_clr_i | input | 8 | Flag clear pulse per channel |
| cnt_o | output | 16 | Base counter value |
| wave_o | output | 8 | Channel waveform outputs |
| flag_o | output | 8 | Sticky match flags |

## Verification
The counter, the toggle states and the flags all update on the clock edge after the inputs that decide them are sampled. Each of these results is therefore due one clock after the stimulus. `wave_o` also follows `inv_i`, `out_dis_i` and `idle_i` combinationally, with zero latency. The bench drives its inputs on the falling edge and advances its own model at the rising edge. It compares every output on the next falling edge, so each result is read exactly one edge after it becomes due. The bench also checks that a period-register cycle returns to zero every n+1 clocks. A full 65,536-clock free run checks the wrap.

// File: rtl/ctt_pkg.sv
package ctt_pkg;
  typedef enum logic [1:0] {
    RSEL_FREE = 2'b00,
    RSEL_CH0  = 2'b01,
    RSEL_PER  = 2'b10,
    RSEL_RSV  = 2'b11
  } rsel_e;
endpackage

// File: rtl/ctt_base_counter.sv
module ctt_base_counter
  import ctt_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  rsel_e         rsel_i,
  input  logic [CW-1:0] period_i,
  input  logic [CW-1:0] cmp0_i,
  output logic [CW-1:0] cnt_o
);
  localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

  logic [CW-1:0] cnt_q;
  logic          restart;

  always_comb begin
    unique case (rsel_i)
      RSEL_CH0: restart = (cnt_q == cmp0_i);
      RSEL_PER: restart = (cnt_q == period_i);
      default:  restart = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (run_i)   cnt_q <= restart ? '0 : cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  a_r1_hold_stopped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> $stable(cnt_q));
  a_r2_free_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && (rsel_i == RSEL_FREE || rsel_i == RSEL_RSV) && cnt_q == CNT_MAX) |=> cnt_q == '0);
  a_r3_ch0_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && rsel_i == RSEL_CH0 && cnt_q == cmp0_i) |=> cnt_q == '0);
  a_r4_period_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && rsel_i == RSEL_PER && cnt_q == period_i) |=> cnt_q == '0);
endmodule

// File: rtl/ctt_channel.sv
module ctt_channel #(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic [CW-1:0] cnt_i,
  input  logic [CW-1:0] cmp_i,
  input  logic          wave_en_i,
  input  logic          idle_i,
  input  logic          inv_i,
  input  logic          dis_i,
  input  logic          clr_i,
  output logic          wave_o,
  output logic          flag_o
);
  logic match;
  logic tgl_q;
  logic flag_q;

  assign match = run_i && (cnt_i == cmp_i);

  // stopped: toggle state tracks idle level
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    tgl_q <= 1'b0;
    else if (!run_i)                tgl_q <= idle_i;
    else if (match && wave_en_i)    tgl_q <= ~tgl_q;
  end

  // set wins over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else         flag_q <= (flag_q & ~clr_i) | match;
  end

  assign wave_o = dis_i ? idle_i : (tgl_q ^ inv_i);
  assign flag_o = flag_q;

  a_r5_toggle_on_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && cnt_i == cmp_i && wave_en_i) |=> tgl_q != $past(tgl_q));
  a_r3_no_toggle_when_period: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !wave_en_i) |=> $stable(tgl_q));
  a_r6_flag_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && cnt_i == cmp_i) |=> flag_q);
  a_r6_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !clr_i) |=> flag_q);
  a_r7_idle_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> tgl_q == $past(idle_i));
endmodule

// File: rtl/cmp_toggle_timer.sv
module cmp_toggle_timer
  import ctt_pkg::*;
#(
  parameter int NCH = 8,
  parameter int CW  = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [1:0]       rsel_i,
  input  logic [CW-1:0]    period_i,
  input  logic [NCH*CW-1:0] cmp_i,
  input  logic [NCH-1:0]   idle_i,
  input  logic [NCH-1:0]   inv_i,
  input  logic [NCH-1:0]   out_dis_i,
  input  logic [NCH-1:0]   flag_clr_i,
  output logic [CW-1:0]    cnt_o,
  output logic [NCH-1:0]   wave_o,
  output logic [NCH-1:0]   flag_o
);
  rsel_e         rsel;
  logic [CW-1:0] cnt;

  assign rsel = rsel_e'(rsel_i);

  ctt_base_counter #(.CW(CW)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run_i),
    .rsel_i   (rsel),
    .period_i (period_i),
    .cmp0_i   (cmp_i[CW-1:0]),
    .cnt_o    (cnt)
  );

  for (genvar j = 0; j < NCH; j++) begin : g_ch
    logic wave_en;
    // channel 0 loses its waveform when it sets the period
    if (j == 0) begin : g_ch0
      assign wave_en = (rsel != RSEL_CH0);
    end else begin : g_chn
      assign wave_en = 1'b1;
    end

    ctt_channel #(.CW(CW)) u_ch (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .run_i     (run_i),
      .cnt_i     (cnt),
      .cmp_i     (cmp_i[j*CW +: CW]),
      .wave_en_i (wave_en),
      .idle_i    (idle_i[j]),
      .inv_i     (inv_i[j]),
      .dis_i     (out_dis_i[j]),
      .clr_i     (flag_clr_i[j]),
      .wave_o    (wave_o[j]),
      .flag_o    (flag_o[j])
    );
  end

  assign cnt_o = cnt;
endmodule

// File: tb/cmp_toggle_timer_test.sv
module cmp_toggle_timer_test;
  localparam int  NCH   = 8;
  localparam int  CW    = 16;
  localparam time CLK_P = 10ns;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             run_i = 1'b0;
  logic [1:0]       rsel_i = 2'b00;
  logic [CW-1:0]    period_i = '0;
  logic [NCH*CW-1:0] cmp_i = '0;
  logic [NCH-1:0]   idle_i = '0, inv_i = '0, out_dis_i = '0, flag_clr_i = '0;
  logic [CW-1:0]    cnt_o;
  logic [NCH-1:0]   wave_o, flag_o;

  int n_tests = 0;
  int n_fail  = 0;

  // bench model state
  logic [CW-1:0]  m_cnt = '0;
  logic [NCH-1:0] m_tgl = '0, m_flag = '0;

  always #(CLK_P/2) clk_i = ~clk_i;

  cmp_toggle_timer #(.NCH(NCH), .CW(CW)) uut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [CW-1:0] cmp_of(int j);
    return cmp_i[j*CW +: CW];
  endfunction

  function automatic logic exp_wave(int j);
    return out_dis_i[j] ? idle_i[j] : (m_tgl[j] ^ inv_i[j]);
  endfunction

  task automatic check_all();
    string lbl;
    if (!run_i)                             lbl = "R1";
    else if (rsel_i == 2'b01)               lbl = "R3";
    else if (rsel_i == 2'b10)               lbl = "R4";
    else                                    lbl = "R2";
    chk({lbl, " cnt"}, 32'(cnt_o), 32'(m_cnt));
    for (int j = 0; j < NCH; j++) begin
      if (out_dis_i[j])                         lbl = "R9";
      else if (inv_i[j])                        lbl = "R8";
      else if (rsel_i == 2'b01 && j == 0)       lbl = "R3";
      else                                      lbl = "R5";
      chk($sformatf("%s wave[%0d]", lbl, j), 32'(wave_o[j]), 32'(exp_wave(j)));
    end
    chk("R6 flags", 32'(flag_o), 32'(m_flag));
  endtask

  // inputs already set (at negedge); advance one clock and check
  task automatic cycle();
    logic [CW-1:0]  n_cnt;
    logic [NCH-1:0] n_tgl, n_flag;
    logic           hit;
    n_cnt = m_cnt; n_tgl = m_tgl; n_flag = m_flag;
    if (run_i) begin
      hit = (rsel_i == 2'b01 && m_cnt == cmp_of(0)) || (rsel_i == 2'b10 && m_cnt == period_i);
      n_cnt = hit ? '0 : m_cnt + 1'b1;
    end
    for (int j = 0; j < NCH; j++) begin
      logic mt;
      mt = run_i && (m_cnt == cmp_of(j));
      if (!run_i) n_tgl[j] = idle_i[j];
      else if (mt && !(rsel_i == 2'b01 && j == 0)) n_tgl[j] = ~m_tgl[j];
      n_flag[j] = (m_flag[j] & ~flag_clr_i[j]) | mt;
    end
    @(posedge clk_i);
    m_cnt = n_cnt; m_tgl = n_tgl; m_flag = n_flag;
    @(negedge clk_i);
    check_all();
  endtask

  initial begin
    #(CLK_P * 190000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int zero_seen;
    int last_zero;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk_i);
    // reset state
    chk("R1 reset cnt", 32'(cnt_o), 32'h0);
    chk("R6 reset flags", 32'(flag_o), 32'h0);
    chk("R5 reset wave", 32'(wave_o), 32'h0);
    rst_ni = 1'b1;

    // R7: load idle while stopped, then start; no change before first match
    idle_i = 8'hA5;
    for (int j = 0; j < NCH; j++) cmp_i[j*CW +: CW] = CW'(20 + j);
    cycle();
    chk("R7 idle loaded", 32'(wave_o), 32'hA5);
    run_i = 1'b1;
    repeat (5) cycle();
    chk("R7 unchanged after start", 32'(wave_o), 32'hA5);

    // R4: period register restart, n+1 clocks between zeros
    run_i = 1'b0; cycle();
    rsel_i = 2'b10; period_i = 16'd9; run_i = 1'b1;
    zero_seen = 0; last_zero = 0;
    for (int c = 1; c <= 40; c++) begin
      cycle();
      if (cnt_o == '0) begin
        if (zero_seen > 0) chk("R4 period n+1", 32'(c - last_zero), 32'd10);
        zero_seen++; last_zero = c;
      end
    end

    // R6: clear and set-wins-over-clear
    flag_clr_i = '1; cycle(); flag_clr_i = '0;
    repeat (12) cycle();

    // R3: channel 0 sets the period
    rsel_i = 2'b01; cmp_i[CW-1:0] = 16'd4; cmp_i[CW +: CW] = 16'd2;
    repeat (30) cycle();

    // R9 and R8: disable and inversion
    out_dis_i = 8'h0F; inv_i = 8'h33;
    repeat (20) cycle();
    out_dis_i = '0; inv_i = '0;

    // R2: full free-running wrap
    rsel_i = 2'b00; cmp_i[CW-1:0] = 16'hFFFF; cmp_i[CW +: CW] = 16'h0000;
    repeat (65600) cycle();
    rsel_i = 2'b11;
    repeat (100) cycle();

    // random mix of modes, compares and controls
    for (int c = 0; c < 30000; c++) begin
      if ($urandom_range(49) == 0) run_i = ~run_i;
      if ($urandom_range(399) == 0) rsel_i = 2'($urandom_range(3));
      if ($urandom_range(99) == 0) period_i = CW'($urandom_range(40));
      if ($urandom_range(29) == 0) cmp_i[$urandom_range(NCH-1)*CW +: CW] = CW'($urandom_range(40));
      if ($urandom_range(99) == 0) idle_i = NCH'($urandom);
      if ($urandom_range(99) == 0) inv_i = NCH'($urandom);
      if ($urandom_range(99) == 0) out_dis_i = NCH'($urandom);
      flag_clr_i = ($urandom_range(7) == 0) ? NCH'($urandom) : '0;
      cycle();
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule